// File: doc/BRIEF.md
# Address-Split Cartridge RAM Controller

This block adds 128 bytes of RAM to a cartridge slot whose bus carries only address and data lines and has no read/write line. The direction of every access is encoded in the address itself. A 256-byte window sits at the bottom of the 4 KB cartridge space. Its lower half accepts writes and its upper half returns data. The low seven offset bits select the RAM byte in both halves.

The block decodes the window and gives the outside ROM a select line and a suppress line. The ROM is never enabled inside the window, so that area reads back as an idle, pulled-high bus, and 3840 bytes of each ROM bank remain usable. For the internal RAM, the block drives an active-low output enable and the read data. It also drives an active-low write strobe built as a one-shot. A newly decoded write address must be stable for a settle period before the strobe falls. The strobe then stays low for a bounded number of cycles and ends before the address is allowed to move.

All timing is counted in system clock cycles. The bench changes the address only between clock edges, and the block registers the address to detect a new access.

Top module: `cart_ram_ctrl`

## Requirements
- R1: After reset, `ram_we_n` and `ram_oe_n` are 1, `data_oe` is 0, and every RAM byte reads back as 0x00.
- R2: The cartridge space is `addr[12]`=1. The window is `addr[12]`=1 with `addr[11:8]`=0. Inside the window, `rom_suppress`=1 and `rom_sel`=0. In the rest of the cartridge space, `rom_sel`=1 and `rom_suppress`=0.
- R3: While `addr[12]`=0, `rom_sel`=0, `rom_suppress`=0, `data_oe`=0, `ram_oe_n`=1 and `ram_we_n`=1, whatever the low address bits are and however long they are held.
- R4: A window offset with bit 7 set is a read. In the same cycle, `data_oe`=1 and `ram_oe_n`=0, `data_out` equals the byte stored at offset bits [6:0], and `ram_we_n` stays 1.
- R5: A window offset with bit 7 clear is a write. Let E0 be the rising edge that first registers the new address. `ram_we_n` stays 1 through edge E0+SETTLE_CYCLES and falls after edge E0+SETTLE_CYCLES+1. With the default SETTLE_CYCLES of 2, it is first seen low at the fourth falling clock edge after the address changes.
- R6: Each write access gives exactly one low pulse of PULSE_CYCLES cycles (default 3). Holding the same write address after the pulse gives no further pulse.
- R7: At the rising edge that ends a complete pulse, the value on `data_in` is stored at offset bits [6:0]. A change of `data_in` earlier in the pulse does not affect what is stored.
- R8: If the address changes while the strobe is low, `ram_we_n` returns to 1 in the same cycle and nothing is stored. A new pulse starts only after the new address has again been stable for the full settle period of R5.
- R9: `ram_we_n` is never 0 while the address differs from its value at the previous rising edge, and never 0 outside the write half of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Cartridge address bus |
| data_in | input | 8 | Data bus as seen by the block (write data) |
| data_out | output | 8 | Read data driven onto the bus |
| data_oe | output | 1 | Drive enable for `data_out`; 0 means tri-stated |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| ram_we_n | output | 1 | Active-low timed RAM write strobe |
| rom_sel | output | 1 | Enables the outside ROM |
| rom_suppress | output | 1 | Forces the ROM off inside the window |

## Verification
The bench times the falling edge of the strobe against the address change. A design that counted one settle cycle too few or too many would show the first low sample one negedge off. It counts the low samples and then holds the write address for many cycles, which would expose a pulse of the wrong width or a strobe that fires again on a held address. It moves the address in the middle of a pulse, both into the read half and to a different write offset. A strobe that ran on, or that wrote the abandoned location, would show up as a late low sample or as changed data on readback. It also changes the write data within the pulse, so a design that latched the data at the start of the pulse would store the wrong byte.

// File: rtl/cart_ram_pkg.sv
package cart_ram_pkg;

   typedef enum logic {
      OS_IDLE  = 1'b0,
      OS_PULSE = 1'b1
   } os_state_e;

   typedef struct packed {
      logic in_cart;
      logic in_win;
      logic wr_hit;
      logic rd_hit;
   } win_dec_t;

endpackage

// File: rtl/cart_win_decode.sv
module cart_win_decode
   import cart_ram_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int RAM_AW = 7
) (
   input  logic [ADDR_W-1:RAM_AW] addr_hi,
   output win_dec_t               dec
);
   localparam int PAGE_LO = RAM_AW + 1;
   localparam int PAGE_HI = ADDR_W - 2;

   logic page_zero;

   assign page_zero   = (addr_hi[PAGE_HI:PAGE_LO] == '0);
   assign dec.in_cart = addr_hi[ADDR_W-1];
   assign dec.in_win  = dec.in_cart && page_zero;
   // lower half of the window writes, upper half reads
   assign dec.wr_hit  = dec.in_win && !addr_hi[RAM_AW];
   assign dec.rd_hit  = dec.in_win &&  addr_hi[RAM_AW];
endmodule

// File: rtl/cart_we_oneshot.sv
module cart_we_oneshot
   import cart_ram_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter int RAM_AW        = 7,
   parameter int SETTLE_CYCLES = 2,
   parameter int PULSE_CYCLES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] data_in,
   output logic              we_n,
   output logic              commit,
   output logic [RAM_AW-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
   localparam int PUL_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
   localparam logic [SET_W-1:0] SET_MAX  = SET_W'(SETTLE_CYCLES);
   localparam logic [PUL_W-1:0] PUL_LAST = PUL_W'(PULSE_CYCLES - 1);

   logic [ADDR_W-1:0] addr_q;
   logic [SET_W-1:0]  stab_cnt;
   logic [PUL_W-1:0]  pul_cnt;
   logic              served;
   os_state_e         state;
   logic              same;
   logic              start;

   assign same   = (addr == addr_q);
   assign start  = (state == OS_IDLE) && same && wr_hit && !served
                   && (stab_cnt == SET_MAX);
   // the strobe is cut combinationally the moment the address moves
   assign we_n   = !((state == OS_PULSE) && same);
   assign commit = (state == OS_PULSE) && same && (pul_cnt == PUL_LAST);
   assign commit_addr = addr[RAM_AW-1:0];
   assign commit_data = data_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         stab_cnt <= '0;
      end else begin
         addr_q <= addr;
         if (!same)
            stab_cnt <= '0;
         else if (stab_cnt != SET_MAX)
            stab_cnt <= stab_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= OS_IDLE;
         pul_cnt <= '0;
         served  <= 1'b0;
      end else begin
         case (state)
            OS_IDLE: begin
               if (!same)
                  served <= 1'b0;
               if (start) begin
                  state   <= OS_PULSE;
                  pul_cnt <= '0;
               end
            end
            OS_PULSE: begin
               if (!same) begin
                  state  <= OS_IDLE;
                  served <= 1'b0;
               end else if (commit) begin
                  state  <= OS_IDLE;
                  served <= 1'b1;
               end else begin
                  pul_cnt <= pul_cnt + 1'b1;
               end
            end
            default: state <= OS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cart_ram_array.sv
module cart_ram_array #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   parameter int RAM_AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RAM_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [RAM_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en && (wr_addr == RAM_AW'(g)))
            mem[g] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cart_ram_ctrl.sv
module cart_ram_ctrl
   import cart_ram_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter int RAM_DEPTH     = 128,
   parameter int SETTLE_CYCLES = 2,
   parameter int PULSE_CYCLES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic              rom_sel,
   output logic              rom_suppress
);
   localparam int RAM_AW = $clog2(RAM_DEPTH);

   if (RAM_DEPTH != (1 << RAM_AW)) begin : g_bad_depth
      $error("RAM_DEPTH must be a power of two");
   end
   if (RAM_AW + 1 > ADDR_W - 2) begin : g_bad_addr
      $error("ADDR_W too narrow for the window");
   end
   if (SETTLE_CYCLES < 1 || PULSE_CYCLES < 1) begin : g_bad_timing
      $error("SETTLE_CYCLES and PULSE_CYCLES must be at least 1");
   end

   win_dec_t          dec;
   logic              commit;
   logic [RAM_AW-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;
   logic [DATA_W-1:0] rd_data;

   cart_win_decode #(
      .ADDR_W (ADDR_W),
      .RAM_AW (RAM_AW)
   ) u_dec (
      .addr_hi (addr[ADDR_W-1:RAM_AW]),
      .dec     (dec)
   );

   cart_we_oneshot #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .RAM_AW        (RAM_AW),
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .PULSE_CYCLES  (PULSE_CYCLES)
   ) u_os (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_hit      (dec.wr_hit),
      .data_in     (data_in),
      .we_n        (ram_we_n),
      .commit      (commit),
      .commit_addr (commit_addr),
      .commit_data (commit_data)
   );

   cart_ram_array #(
      .DATA_W (DATA_W),
      .DEPTH  (RAM_DEPTH),
      .RAM_AW (RAM_AW)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_addr (commit_addr),
      .wr_data (commit_data),
      .rd_addr (addr[RAM_AW-1:0]),
      .rd_data (rd_data)
   );

   assign data_oe      = dec.rd_hit;
   assign ram_oe_n     = !dec.rd_hit;
   assign data_out     = dec.rd_hit ? rd_data : '0;
   assign rom_sel      = dec.in_cart && !dec.in_win;
   assign rom_suppress = dec.in_win;
endmodule

module cart_ram_ctrl_chk #(
   parameter int ADDR_W        = 13,
   parameter int RAM_AW        = 7,
   parameter int SETTLE_CYCLES = 2,
   parameter int PULSE_CYCLES  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ram_we_n,
   input logic              ram_oe_n,
   input logic              data_oe,
   input logic              rom_sel,
   input logic              rom_suppress
);
   logic [ADDR_W-1:0] a_prev;
   logic [7:0]        stable_run;
   logic [7:0]        low_run;
   logic              wr_zone;

   assign wr_zone = addr[ADDR_W-1] && (addr[ADDR_W-2:RAM_AW+1] == '0)
                    && !addr[RAM_AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev     <= '0;
         stable_run <= '0;
         low_run    <= '0;
      end else begin
         a_prev <= addr;
         if (addr != a_prev)
            stable_run <= '0;
         else if (stable_run != 8'hFF)
            stable_run <= stable_run + 8'd1;
         if (!ram_we_n && low_run != 8'hFF)
            low_run <= low_run + 8'd1;
         else if (ram_we_n)
            low_run <= '0;
      end
   end

   a_r2_rom_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_sel && rom_suppress));

   a_r3_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !addr[ADDR_W-1] |-> (ram_we_n && ram_oe_n && !data_oe && !rom_sel && !rom_suppress));

   a_r4_no_we_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_we_n && !ram_oe_n));

   a_r5_settled_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> (32'(stable_run) >= SETTLE_CYCLES + 1));

   a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      32'(low_run) <= PULSE_CYCLES);

   a_r9_addr_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (addr == a_prev));

   a_r9_we_in_write_half: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> wr_zone);
endmodule

bind cart_ram_ctrl cart_ram_ctrl_chk #(
   .ADDR_W        (ADDR_W),
   .RAM_AW        (RAM_AW),
   .SETTLE_CYCLES (SETTLE_CYCLES),
   .PULSE_CYCLES  (PULSE_CYCLES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .ram_we_n     (ram_we_n),
   .ram_oe_n     (ram_oe_n),
   .data_oe      (data_oe),
   .rom_sel      (rom_sel),
   .rom_suppress (rom_suppress)
);

// File: tb/test_cart_ram_ctrl.sv
`timescale 1ns/1ps
module test_cart_ram_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 2;
   localparam int PULSE      = 3;
   localparam int FIRST_LOW  = SETTLE + 2;

   typedef struct {
      string      tag;
      logic [7:0] val;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  data_in = '0;
   logic [7:0]  data_out;
   logic        data_oe, ram_oe_n, ram_we_n, rom_sel, rom_suppress;

   int   checks = 0;
   int   fails = 0;
   logic rd_req = 1'b0;
   logic [7:0] model [128];
   exp_t exp_q[$];
   exp_t item;

   always #(CLK_PERIOD/2) clk = ~clk;

   cart_ram_ctrl #(
      .SETTLE_CYCLES (SETTLE),
      .PULSE_CYCLES  (PULSE)
   ) i_cart_ram_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (addr),
      .data_in      (data_in),
      .data_out     (data_out),
      .data_oe      (data_oe),
      .ram_oe_n     (ram_oe_n),
      .ram_we_n     (ram_we_n),
      .rom_sel      (rom_sel),
      .rom_suppress (rom_suppress)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // monitor: compares read results against the scoreboard queue
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rd_req && exp_q.size() != 0) begin
            item = exp_q.pop_front();
            chk({item.tag, " data_out"}, 32'(data_out), 32'(item.val));
            chk({item.tag, " R4 data_oe"}, 32'(data_oe), 1);
            chk({item.tag, " R4 ram_oe_n"}, 32'(ram_oe_n), 0);
            chk({item.tag, " R4 we idle"}, 32'(ram_we_n), 1);
         end
      end
   end

   task automatic do_read(input logic [6:0] off, input string tag);
      @(negedge clk);
      addr = 13'h1080 | 13'(off);
      exp_q.push_back('{tag: tag, val: model[off]});
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   // full write: checks timing; data switches to fin_val at the first low sample
   task automatic do_write(input logic [6:0] off, input logic [7:0] v0,
                           input logic [7:0] fin_val, input string tag);
      int first;
      int lows;
      first = 0;
      lows  = 0;
      @(negedge clk);
      addr    = 13'h1000 | 13'(off);
      data_in = v0;
      for (int i = 1; i <= 14; i++) begin
         @(negedge clk);
         if (!ram_we_n) begin
            lows++;
            if (first == 0) begin
               first   = i;
               data_in = fin_val;
            end
         end
      end
      chk({tag, " R5 first low negedge"}, 32'(first), 32'(FIRST_LOW));
      chk({tag, " R6 low width"}, 32'(lows), 32'(PULSE));
      model[off] = fin_val;
   endtask

   initial begin
      int lows;
      int first;
      for (int k = 0; k < 128; k++) model[k] = 8'h00;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 we_n in reset", 32'(ram_we_n), 1);
      chk("R1 data_oe in reset", 32'(data_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe_n after reset", 32'(ram_oe_n), 1);
      do_read(7'h05, "R1 cleared byte");

      // R2: window decode
      @(negedge clk); addr = 13'h1100; #1;
      chk("R2 rom_sel above window", 32'(rom_sel), 1);
      chk("R2 suppress above window", 32'(rom_suppress), 0);
      @(negedge clk); addr = 13'h10FF; #1;
      chk("R2 suppress top of window", 32'(rom_suppress), 1);
      chk("R2 rom_sel top of window", 32'(rom_sel), 0);
      @(negedge clk); addr = 13'h1000; #1;
      chk("R2 suppress bottom of window", 32'(rom_suppress), 1);
      @(negedge clk); addr = 13'h1FFF; #1;
      chk("R2 rom_sel top of space", 32'(rom_sel), 1);

      // R3: outside cartridge space, held with write-like low bits
      @(negedge clk); addr = 13'h0010;
      lows = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!ram_we_n || data_oe || rom_sel || rom_suppress || !ram_oe_n) lows++;
      end
      chk("R3 idle outside space", 32'(lows), 0);
      @(negedge clk); addr = 13'h0090; #1;
      chk("R3 no drive outside space", 32'(data_oe), 0);

      // R5 R6 R7: plain writes with data switched mid-pulse
      do_write(7'h00, 8'h11, 8'hA5, "W0");
      do_write(7'h7F, 8'h22, 8'h3C, "W7F");
      do_write(7'h21, 8'hFF, 8'hFF, "W21");
      do_read(7'h00, "R7 readback 00");
      do_read(7'h7F, "R7 readback 7F");
      do_read(7'h21, "R7 readback 21");

      // R6: held write address must not retrigger
      @(negedge clk); addr = 13'h1033; data_in = 8'h66;
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!ram_we_n) lows++;
      end
      chk("R6 single pulse on held address", 32'(lows), 32'(PULSE));
      model[7'h33] = 8'h66;
      do_read(7'h33, "R6 held write stored");

      // R8: abort into the read half
      @(negedge clk); addr = 13'h1010; data_in = 8'h5A;
      for (int i = 1; i <= FIRST_LOW; i++) @(negedge clk);
      chk("R8 strobe low before abort", 32'(ram_we_n), 0);
      addr = 13'h1090; #1;
      chk("R8 strobe cut at once", 32'(ram_we_n), 1);
      lows = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!ram_we_n) lows++;
      end
      chk("R8 no pulse after abort", 32'(lows), 0);
      do_read(7'h10, "R8 aborted byte unchanged");

      // R8: abort onto a new write offset, fresh settle
      @(negedge clk); addr = 13'h1011; data_in = 8'h77;
      for (int i = 1; i <= FIRST_LOW; i++) @(negedge clk);
      chk("R8 low on first offset", 32'(ram_we_n), 0);
      addr = 13'h1012; data_in = 8'h99; #1;
      chk("R9 strobe high on address move", 32'(ram_we_n), 1);
      first = 0; lows = 0;
      for (int i = 1; i <= 14; i++) begin
         @(negedge clk);
         if (!ram_we_n) begin
            lows++;
            if (first == 0) first = i;
         end
      end
      chk("R8 fresh settle on new offset", 32'(first), 32'(FIRST_LOW));
      chk("R8 full pulse on new offset", 32'(lows), 32'(PULSE));
      model[7'h12] = 8'h99;
      do_read(7'h11, "R8 abandoned byte unchanged");
      do_read(7'h12, "R8 new byte stored");

      // R9: window edge addresses never strobe while reading
      @(negedge clk); addr = 13'h1080;
      lows = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (!ram_we_n) lows++;
      end
      chk("R9 no strobe in read half", 32'(lows), 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired (R1..R9 run incomplete) actual=hung expected=done");
      summary();
      $finish;
   end
endmodule